// File: doc/BRIEF.md
# Fault-tolerant clock edge voter

One node of a redundant clock cluster has to stay in phase with its peers even when some of those peers are maliciously faulty. This block is that node's voting and phase-detect stage. It watches the edge pulses of the N-1 other nodes and of its own clock. All of these pulses are already synchronized to a fast sampling clock. Within one observation window, each pulse is timestamped in sampling ticks. The block then picks the K-th peer edge to arrive as the reference and reports how many ticks the local edge lies after it (positive) or before it (negative). A downstream loop filter uses that signed error to steer the local oscillator.

K is fixed at elaboration from the cluster size N and the fault budget M as floor((N+M)/2). This is the smallest integer above (N+M)/2 - 1, and it keeps the good clocks from splitting into more than one self-sustaining group. A peer that pulses more than once in a window is dropped from the ranking, and so is a peer that stays silent. The local edge is never ranked; it is only compared against the reference.

The control is a three-state machine:
- VS_IDLE goes to VS_OPEN on the first sample that carries any edge.
- VS_OPEN goes to VS_EVAL when the tick counter reaches WIN-1.
- VS_EVAL always returns to VS_IDLE after one sample. In that sample the result is registered and the window storage is cleared.

Top module: `clk_edge_voter`

## Requirements
- R1: The reference is the K-th earliest timestamp among the valid peers, with K = floor((N+M)/2). This gives K=2 for N=4, M=1 (the median of three peers) and K=4 for N=7, M=2. Elaboration stops with an error when N <= 3M.
- R2: A window opens on the first sample in VS_IDLE where any edge input is high. That sample has time 0, and later samples have times 1 to WIN-1. The result appears on the outputs in the clock after the sample WIN ticks after the window opened.
- R3: A peer that pulses two or more times within a window is excluded from the ranking, and so is a peer that never pulses.
- R4: phase_err is the two's-complement value of (own time - reference time), ERR_W = clog2(WIN)+1 bits wide. A positive value means the local edge was late.
- R5: phase_err saturates to +sat_limit when the difference exceeds sat_limit, and to -sat_limit when the difference is below -sat_limit.
- R6: own_early is 1 exactly when the unsaturated difference is negative.
- R7: err_valid is a one-clock pulse, at most one per window. It does not fire when the local edge did not occur exactly once in the window, or when fewer than K valid peers exist; such a window just times out and clears.
- R8: After reset, err_valid, phase_err and own_early are all 0.
- R9: Edges that arrive on the VS_EVAL sample are ignored. A new window can open on the sample right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_edge | input | 1 | One-tick pulse marking the local clock edge |
| peer_edge | input | N-1 | One-tick pulses marking each peer clock edge |
| sat_limit | input | clog2(WIN) | Magnitude limit for phase_err |
| err_valid | output | 1 | One-clock strobe marking a new result |
| phase_err | output | clog2(WIN)+1 | Signed tick difference, own minus reference, saturated |
| own_early | output | 1 | Local edge arrived before the reference |

## Verification
The assertions assume two things about the inputs:
- Each edge arrives as a pulse exactly one sampling tick wide, so that a repeated pulse is a genuine double fire.
- sat_limit holds still across the evaluation sample and the clock that follows it.

The bench keeps to both. It drives only single-tick pulses, and a deliberate repeat always follows the first pulse of that input by two ticks. It changes sat_limit only between windows, while the inputs are idle. All event offsets within a case span fewer than WIN ticks, so every stimulated edge lands inside the window it belongs to. The exception is the directed case for R9, which places edges on the evaluation sample and just after it on purpose.

// File: rtl/clk_vote_pkg.sv
package clk_vote_pkg;
    typedef enum logic [1:0] {
        VS_IDLE = 2'd0,
        VS_OPEN = 2'd1,
        VS_EVAL = 2'd2
    } vote_state_e;
endpackage

// File: rtl/clk_vote_stamp.sv
module clk_vote_stamp #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture_en,
    input  logic          pulse,
    input  logic [TW-1:0] now,
    output logic [TW-1:0] stamp,
    output logic          seen_once
);
    logic [1:0] hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits  <= 2'd0;
            stamp <= '0;
        end else if (clear) begin
            hits <= 2'd0;
        end else if (capture_en && pulse) begin
            if (hits == 2'd0) stamp <= now;
            if (hits != 2'd2) hits <= hits + 2'd1;
        end
    end

    assign seen_once = (hits == 2'd1);

    // R3: the first arrival time is kept even when further pulses come
    a_r3_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != 2'd0 && !clear) |=> $stable(stamp));
endmodule

// File: rtl/clk_vote_rank.sv
module clk_vote_rank #(
    parameter int NP = 3,
    parameter int K  = 2,
    parameter int TW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*TW-1:0] stamps,
    input  logic [NP-1:0]    valid,
    output logic [TW-1:0]    ref_time,
    output logic             ref_ok
);
    logic [NP-1:0] hit;

    for (genvar i = 0; i < NP; i++) begin : g_rank
        always_comb begin
            int r;
            r = 0;
            for (int j = 0; j < NP; j++) begin
                if (j != i && valid[j]) begin
                    if (stamps[j*TW +: TW] < stamps[i*TW +: TW] ||
                        (stamps[j*TW +: TW] == stamps[i*TW +: TW] && j < i))
                        r = r + 1;
                end
            end
            hit[i] = valid[i] && (r == K - 1);
        end
    end

    always_comb begin
        ref_time = '0;
        for (int i = 0; i < NP; i++) begin
            if (hit[i]) ref_time = ref_time | stamps[i*TW +: TW];
        end
    end

    assign ref_ok = |hit;

    // R1: ties are broken by index, so at most one peer holds rank K
    a_r1_one_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R1: a reference exists only with at least K ranked peers
    a_r1_ref_count: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ok |-> ($countones(valid) >= K));
endmodule

// File: rtl/clk_edge_voter.sv
module clk_edge_voter
    import clk_vote_pkg::*;
#(
    parameter int N   = 4,
    parameter int M   = 1,
    parameter int WIN = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        own_edge,
    input  logic [N-2:0]                peer_edge,
    input  logic [$clog2(WIN)-1:0]      sat_limit,
    output logic                        err_valid,
    output logic signed [$clog2(WIN):0] phase_err,
    output logic                        own_early
);
    localparam int NPEER = N - 1;
    localparam int K     = (N + M) / 2;
    localparam int TW    = $clog2(WIN);
    localparam int ERR_W = TW + 1;

    if (N <= 3 * M) begin : g_cfg_bad
        $error("clk_edge_voter: cluster size must exceed three times the fault budget");
    end
    if (WIN < 2) begin : g_win_bad
        $error("clk_edge_voter: window must be at least two ticks");
    end

    vote_state_e   state, state_nxt;
    logic [TW-1:0] tick;
    logic [TW-1:0] now;
    logic          any_edge, capture_en, clear;

    assign any_edge   = own_edge | (|peer_edge);
    assign now        = (state == VS_IDLE) ? '0 : tick;
    assign capture_en = (state != VS_EVAL);
    assign clear      = (state == VS_EVAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= VS_IDLE;
            tick  <= '0;
        end else begin
            state <= state_nxt;
            if (state == VS_IDLE)      tick <= TW'(1);
            else if (state == VS_OPEN) tick <= tick + 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            VS_IDLE: if (any_edge) state_nxt = VS_OPEN;
            VS_OPEN: if (tick == TW'(WIN - 1)) state_nxt = VS_EVAL;
            VS_EVAL: state_nxt = VS_IDLE;
            default: state_nxt = VS_IDLE;
        endcase
    end

    logic [TW-1:0]       own_stamp;
    logic                own_once;
    logic [NPEER*TW-1:0] peer_stamps;
    logic [NPEER-1:0]    peer_once;

    clk_vote_stamp #(.TW(TW)) u_own (
        .clk(clk), .rst_n(rst_n), .clear(clear), .capture_en(capture_en),
        .pulse(own_edge), .now(now), .stamp(own_stamp), .seen_once(own_once)
    );

    for (genvar p = 0; p < NPEER; p++) begin : g_peer
        clk_vote_stamp #(.TW(TW)) u_peer (
            .clk(clk), .rst_n(rst_n), .clear(clear), .capture_en(capture_en),
            .pulse(peer_edge[p]), .now(now),
            .stamp(peer_stamps[p*TW +: TW]), .seen_once(peer_once[p])
        );
    end

    logic [TW-1:0] ref_time;
    logic          ref_ok;

    clk_vote_rank #(.NP(NPEER), .K(K), .TW(TW)) u_rank (
        .clk(clk), .rst_n(rst_n), .stamps(peer_stamps), .valid(peer_once),
        .ref_time(ref_time), .ref_ok(ref_ok)
    );

    logic signed [ERR_W-1:0] raw_diff, lim, sat_val;

    always_comb begin
        raw_diff = $signed({1'b0, own_stamp}) - $signed({1'b0, ref_time});
        lim      = $signed({1'b0, sat_limit});
        if (raw_diff > lim)       sat_val = lim;
        else if (raw_diff < -lim) sat_val = -lim;
        else                      sat_val = raw_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            phase_err <= '0;
            own_early <= 1'b0;
        end else begin
            err_valid <= 1'b0;
            if (state == VS_EVAL && own_once && ref_ok) begin
                err_valid <= 1'b1;
                phase_err <= sat_val;
                own_early <= (raw_diff < 0);
            end
        end
    end

    // R7: the result strobe lasts a single clock
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    // R2: a result only follows an evaluation sample
    a_r2_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ($past(state) == VS_EVAL));

    // R9: evaluation lasts one sample and returns to idle
    a_r9_eval_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_EVAL) |=> (state == VS_IDLE));

    // R5: reported error stays within the limit in force at evaluation
    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (phase_err <= $signed({1'b0, $past(sat_limit)}) &&
                       phase_err >= -$signed({1'b0, $past(sat_limit)})));

    // R6: the early flag agrees with the sign of the reported error
    a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (own_early ? (phase_err <= 0) : (phase_err >= 0)));
endmodule

// File: tb/clk_edge_voter_bench.sv
module clk_edge_voter_bench;
    localparam int N   = 4;
    localparam int M   = 1;
    localparam int WIN = 16;
    localparam int K   = (N + M) / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              own_edge = 1'b0;
    logic [N-2:0]      peer_edge = '0;
    logic [3:0]        sat_limit = 4'd15;
    logic              err_valid;
    logic signed [4:0] phase_err;
    logic              own_early;

    int nchecks = 0;
    int nfail   = 0;

    always #10 clk = ~clk;

    clk_edge_voter #(.N(N), .M(M), .WIN(WIN)) u_clk_edge_voter (
        .clk(clk), .rst_n(rst_n), .own_edge(own_edge), .peer_edge(peer_edge),
        .sat_limit(sat_limit), .err_valid(err_valid), .phase_err(phase_err),
        .own_early(own_early)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int own_t, input bit own_dbl, input int p0,
                            input int p1, input int p2, input int dbl_peer,
                            input int sat);
        int p[3];
        int vp[3];
        int nv, mn, last, raw, exp_err, nvalid, got_it, got_err, got_early;
        bit own_ok, exp_ok;
        p[0] = p0; p[1] = p1; p[2] = p2;
        mn = 1000;
        if (own_t >= 0) mn = own_t;
        for (int i = 0; i < 3; i++) if (p[i] >= 0 && p[i] < mn) mn = p[i];
        if (mn == 1000) mn = 0;
        nv = 0;
        for (int i = 0; i < 3; i++) begin
            if (p[i] >= 0 && dbl_peer != i) begin
                vp[nv] = p[i];
                nv++;
            end
        end
        for (int a = 0; a < 3; a++)
            for (int b = 0; b + 1 < nv; b++)
                if (vp[b] > vp[b+1]) begin
                    int t;
                    t = vp[b]; vp[b] = vp[b+1]; vp[b+1] = t;
                end
        own_ok  = (own_t >= 0) && !own_dbl;
        exp_ok  = own_ok && (nv >= K);
        raw     = exp_ok ? (own_t - vp[K-1]) : 0;
        exp_err = (raw > sat) ? sat : ((raw < -sat) ? -sat : raw);
        sat_limit = 4'(sat);
        last = mn + WIN + 4;
        nvalid = 0; got_it = -1; got_err = 0; got_early = 0;
        for (int it = 0; it <= last; it++) begin
            @(negedge clk);
            if (err_valid) begin
                nvalid++;
                got_it    = it;
                got_err   = phase_err;
                got_early = own_early;
            end
            own_edge = (own_t >= 0) && (it == own_t || (own_dbl && it == own_t + 2));
            for (int i = 0; i < 3; i++)
                peer_edge[i] = (p[i] >= 0) && (it == p[i] || (dbl_peer == i && it == p[i] + 2));
        end
        @(negedge clk);
        own_edge = 1'b0;
        peer_edge = '0;
        if (dbl_peer >= 0)
            check(nvalid == (exp_ok ? 1 : 0), "R3 result count with double-firing peer", nvalid, exp_ok ? 1 : 0);
        else
            check(nvalid == (exp_ok ? 1 : 0), "R7 result count per window", nvalid, exp_ok ? 1 : 0);
        if (exp_ok && nvalid == 1) begin
            check(got_it == mn + WIN + 1, "R2 result timing", got_it, mn + WIN + 1);
            if (raw != exp_err)
                check(got_err == exp_err, "R5 saturated error", got_err, exp_err);
            else
                check(got_err == exp_err, "R1 R4 error against K-th peer", got_err, exp_err);
            check(got_early == (raw < 0 ? 1 : 0), "R6 early flag", got_early, raw < 0 ? 1 : 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        int owns[4];
        int sats[3];
        int idx;
        int nvalid, first_err;
        owns[0] = -1; owns[1] = 0; owns[2] = 3; owns[3] = 6;
        sats[0] = 1;  sats[1] = 3; sats[2] = 15;

        repeat (3) @(negedge clk);
        check(err_valid == 1'b0, "R8 err_valid after reset", err_valid, 0);
        check(phase_err == 0, "R8 phase_err after reset", phase_err, 0);
        check(own_early == 1'b0, "R8 own_early after reset", own_early, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // near-exhaustive sweep of peer timing with a single-firing local edge
        idx = 0;
        for (int o = 0; o < 4; o++)
            for (int a = -1; a <= 5; a++)
                for (int b = -1; b <= 5; b++)
                    for (int c = -1; c <= 5; c++) begin
                        run_case(owns[o], 1'b0, a, b, c, -1, sats[idx % 3]);
                        idx++;
                    end

        // R3: one peer fires twice and must drop out of the ranking
        for (int d = 0; d < 3; d++)
            for (int a = 0; a <= 3; a++)
                for (int b = 0; b <= 3; b++)
                    for (int c = 0; c <= 3; c++)
                        run_case((a + c) % 5, 1'b0, a, b, c, d, 15);

        // R7: a local edge that fires twice gives no result
        for (int a = 0; a <= 3; a++)
            run_case(1, 1'b1, a, 2, 4, -1, 15);

        // R9: edges on the evaluation sample are ignored
        sat_limit = 4'd15;
        nvalid = 0; first_err = 99;
        for (int it = 0; it <= 2 * WIN + 8; it++) begin
            @(negedge clk);
            if (err_valid) begin
                if (nvalid == 0) first_err = phase_err;
                nvalid++;
            end
            own_edge     = (it == 0) || (it == WIN);
            peer_edge[0] = (it == 0) || (it == WIN + 1);
            peer_edge[1] = (it == 1) || (it == WIN + 1);
            peer_edge[2] = (it == 2) || (it == WIN + 2);
        end
        own_edge = 1'b0;
        peer_edge = '0;
        check(nvalid == 1, "R9 edge on evaluation sample ignored", nvalid, 1);
        check(first_err == -1, "R9 first window result", first_err, -1);
        run_case(2, 1'b0, 0, 4, 1, -1, 15);

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule